// File: doc/BRIEF.md
# Regulator Power-Good Supervisor

This block is the sequencing core of a multiphase regulator controller. It decides when the regulator may ramp its output, when the power-good output may be raised, and when a fault must shut the regulator down for good. All analog parts are outside it and reach it as single-bit flags: the undervoltage, overvoltage and overcurrent comparators, the soft-start ramp's completion signal, the enable pins, the power-on-reset monitor and the detector for a no-load voltage code.

Faults fall into two classes. An undervoltage is recoverable. Power-good drops while the output sags and comes back by itself once the output recovers, with no new ramp. An overvoltage or overcurrent trips the controller into a latched-off state. Only a supply restart clears that state: any enable input going low, or the power-on-reset monitor going low. A fresh soft-start must then complete before power-good can rise again.

The sequencer has five states:
- OFF: shut down.
- RAMP: soft-start in progress.
- REG: regulating.
- UVWAIT: undervoltage wait.
- TRIP: latched off.

It has these transitions:
- start: OFF to RAMP.
- settle: RAMP to REG.
- settle-low: RAMP to UVWAIT.
- sag: REG to UVWAIT.
- recover: UVWAIT to REG.
- trip: RAMP, REG or UVWAIT to TRIP.
- drop: RAMP, REG or UVWAIT to OFF.
- clear: TRIP to OFF.

All outputs are registered. Each output reflects, one clock after an input change, the state that the change selects.

Top module: `pg_supervisor`

## Requirements
- R1: While reset is held and after it is released, `pgood`, `latched_off` and `ss_start` are 0 until the inputs request a start.
- R2: In OFF, the first cycle in which every `en` bit is 1, `por_ok` is 1 and `noload_code` is 0 gives `ss_start` = 1 on the next cycle. `ss_start` is 0 on the cycle after that. `pgood` is 0 throughout the ramp.
- R3: During the ramp, a cycle with `ss_done` = 1 and all three fault flags 0 gives `pgood` = 1 on the next cycle.
- R4: If the ramp completes while `uv_flag` = 1, `pgood` stays 0. It rises on the cycle after `uv_flag` returns to 0, with no new `ss_start`.
- R5: While regulating, `uv_flag` = 1 alone gives `pgood` = 0 on the next cycle with `latched_off` = 0. `pgood` returns to 1 on the cycle after `uv_flag` clears, with no `ss_start`.
- R6: While ramping, regulating or waiting on undervoltage, `ov_flag` = 1 or `oc_flag` = 1 gives `pgood` = 0 and `latched_off` = 1 on the next cycle.
- R7: When `uv_flag` and `ov_flag` (or `oc_flag`) are 1 in the same cycle, the latching fault wins and `latched_off` becomes 1.
- R8: Once `latched_off` is 1, it stays 1 with `pgood` = 0 while every `en` bit and `por_ok` stay 1. This holds when the fault flags clear, when `ss_done` toggles and when `noload_code` is asserted.
- R9: In the latched state, any `en` bit at 0 or `por_ok` at 0 gives `latched_off` = 0 on the next cycle. Restoring them gives a new `ss_start` pulse. `pgood` rises only after the new ramp completes.
- R10: While ramping or regulating, any `en` bit at 0, `por_ok` at 0 or `noload_code` at 1 gives `pgood` = 0 and `latched_off` = 0 on the next cycle. Returning to run conditions starts a new ramp.
- R11: `pgood` and `latched_off` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset to OFF |
| en | input | N_EN | Enable inputs; all must be 1 to run |
| por_ok | input | 1 | Power-on-reset monitor reports supplies good |
| noload_code | input | 1 | Voltage code requests no output |
| ss_done | input | 1 | Soft-start ramp has reached target |
| uv_flag | input | 1 | Undervoltage comparator output |
| ov_flag | input | 1 | Overvoltage comparator output |
| oc_flag | input | 1 | Overcurrent comparator output |
| pgood | output | 1 | Power-good, active high |
| latched_off | output | 1 | Controller is latched off by a fault |
| ss_start | output | 1 | One-cycle request to begin soft-start |

## Verification
Every output changes exactly one clock edge after the input cycle that causes it. The one register on the path is the output register, which is loaded from the next-state decode. The bench drives inputs on the falling edge and lets one rising edge pass. It then samples on the following falling edge, so each expected value is compared in the first cycle it is due. For multi-cycle holds such as the latched state and the undervoltage wait, the bench samples on every cycle of the hold.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_RAMP   = 3'd1,
        ST_REG    = 3'd2,
        ST_UVWAIT = 3'd3,
        ST_TRIP   = 3'd4
    } pg_state_e;

endpackage

// File: rtl/pg_run_qual.sv
module pg_run_qual #(
    parameter int N_EN = 2
) (
    input  logic [N_EN-1:0] en,
    input  logic            por_ok,
    input  logic            noload_code,
    output logic            run_ok,
    output logic            clear_req
);

    logic all_en;

    // Collapse the enable vector; every input must be high to run.
    always_comb begin
        all_en = 1'b1;
        for (int i = 0; i < N_EN; i++) begin
            all_en = all_en & en[i];
        end
    end

    // A latched trip is released only by a supply-side restart,
    // never by the voltage code detector.
    assign run_ok    = all_en & por_ok & ~noload_code;
    assign clear_req = ~all_en | ~por_ok;

endmodule

// File: rtl/pg_fault_class.sv
module pg_fault_class (
    input  logic uv_flag,
    input  logic ov_flag,
    input  logic oc_flag,
    output logic trip,
    output logic sag
);

    // Latching faults outrank the recoverable one.
    assign trip = ov_flag | oc_flag;
    assign sag  = uv_flag & ~trip;

endmodule

// File: rtl/pg_seq_fsm.sv
module pg_seq_fsm
    import pg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_ok,
    input  logic clear_req,
    input  logic trip,
    input  logic sag,
    input  logic ss_done,
    output logic pgood,
    output logic latched_off,
    output logic ss_start
);

    pg_state_e state_q;
    pg_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decode: disable first, then latching fault, then sag
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (run_ok) state_d = ST_RAMP;                       // start
            end
            ST_RAMP: begin
                if (!run_ok)      state_d = ST_OFF;                  // drop
                else if (trip)    state_d = ST_TRIP;                 // trip
                else if (ss_done) state_d = sag ? ST_UVWAIT : ST_REG; // settle / settle-low
            end
            ST_REG: begin
                if (!run_ok)  state_d = ST_OFF;                      // drop
                else if (trip) state_d = ST_TRIP;                    // trip
                else if (sag)  state_d = ST_UVWAIT;                  // sag
            end
            ST_UVWAIT: begin
                if (!run_ok)   state_d = ST_OFF;                     // drop
                else if (trip) state_d = ST_TRIP;                    // trip
                else if (!sag) state_d = ST_REG;                     // recover
            end
            ST_TRIP: begin
                if (clear_req) state_d = ST_OFF;                     // clear
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Registered outputs, aligned with the state they describe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pgood       <= 1'b0;
            latched_off <= 1'b0;
            ss_start    <= 1'b0;
        end else begin
            pgood       <= (state_d == ST_REG);
            latched_off <= (state_d == ST_TRIP);
            ss_start    <= (state_q == ST_OFF) && (state_d == ST_RAMP);
        end
    end

endmodule

// File: rtl/pg_supervisor.sv
module pg_supervisor #(
    parameter int N_EN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EN-1:0] en,
    input  logic            por_ok,
    input  logic            noload_code,
    input  logic            ss_done,
    input  logic            uv_flag,
    input  logic            ov_flag,
    input  logic            oc_flag,
    output logic            pgood,
    output logic            latched_off,
    output logic            ss_start
);

    logic run_ok;
    logic clear_req;
    logic trip;
    logic sag;

    pg_run_qual #(.N_EN(N_EN)) run_qual_i (
        .en          (en),
        .por_ok      (por_ok),
        .noload_code (noload_code),
        .run_ok      (run_ok),
        .clear_req   (clear_req)
    );

    pg_fault_class fault_class_i (
        .uv_flag (uv_flag),
        .ov_flag (ov_flag),
        .oc_flag (oc_flag),
        .trip    (trip),
        .sag     (sag)
    );

    pg_seq_fsm seq_fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_ok      (run_ok),
        .clear_req   (clear_req),
        .trip        (trip),
        .sag         (sag),
        .ss_done     (ss_done),
        .pgood       (pgood),
        .latched_off (latched_off),
        .ss_start    (ss_start)
    );

endmodule

// File: rtl/pg_supervisor_chk.sv
module pg_supervisor_chk #(
    parameter int N_EN = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_EN-1:0] en,
    input logic            por_ok,
    input logic            noload_code,
    input logic            ss_done,
    input logic            uv_flag,
    input logic            ov_flag,
    input logic            oc_flag,
    input logic            pgood,
    input logic            latched_off,
    input logic            ss_start
);

    logic run_in;
    assign run_in = (&en) & por_ok & ~noload_code;

    a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ss_start |=> !ss_start);

    a_r2_low_in_ramp: assert property (@(posedge clk) disable iff (!rst_n)
        ss_start |-> !pgood);

    a_r3_rise_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> $past(!uv_flag && !ov_flag && !oc_flag && run_in));

    a_r5_uv_not_latching: assert property (@(posedge clk) disable iff (!rst_n)
        (!latched_off && uv_flag && !ov_flag && !oc_flag) |=> !latched_off);

    a_r6_trip_from_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (pgood && run_in && (ov_flag || oc_flag)) |=> (latched_off && !pgood));

    a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_off && (&en) && por_ok) |=> latched_off);

    a_r10_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run_in |=> !pgood);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pgood && latched_off));

endmodule

bind pg_supervisor pg_supervisor_chk #(.N_EN(N_EN)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .por_ok      (por_ok),
    .noload_code (noload_code),
    .ss_done     (ss_done),
    .uv_flag     (uv_flag),
    .ov_flag     (ov_flag),
    .oc_flag     (oc_flag),
    .pgood       (pgood),
    .latched_off (latched_off),
    .ss_start    (ss_start)
);

// File: tb/pg_supervisor_tb_top.sv
module pg_supervisor_tb_top;

    localparam int N_EN = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N_EN-1:0] en = '0;
    logic            por_ok = 1'b0;
    logic            noload_code = 1'b0;
    logic            ss_done = 1'b0;
    logic            uv_flag = 1'b0;
    logic            ov_flag = 1'b0;
    logic            oc_flag = 1'b0;
    logic            pgood;
    logic            latched_off;
    logic            ss_start;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pg_supervisor #(.N_EN(N_EN)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .por_ok      (por_ok),
        .noload_code (noload_code),
        .ss_done     (ss_done),
        .uv_flag     (uv_flag),
        .ov_flag     (ov_flag),
        .oc_flag     (oc_flag),
        .pgood       (pgood),
        .latched_off (latched_off),
        .ss_start    (ss_start)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
        if (pgood === 1'b1 && latched_off === 1'b1) begin
            errors++;
            $display("FAIL R11 pgood&latched_off actual=1 expected=0 at %0t", $time);
        end
    endtask

    task automatic quiet_flags();
        uv_flag = 1'b0; ov_flag = 1'b0; oc_flag = 1'b0; ss_done = 1'b0; noload_code = 1'b0;
    endtask

    task automatic go_off();
        quiet_flags();
        en = '0; por_ok = 1'b1;
        step(); step();
    endtask

    // Start from OFF, ramp and reach regulation.
    task automatic bring_up(input string req);
        quiet_flags();
        en = '1; por_ok = 1'b1;
        step();
        chk(req, "ss_start on start", ss_start, 1'b1);
        chk(req, "pgood in ramp", pgood, 1'b0);
        ss_done = 1'b1;
        step();
        chk(req, "pgood after ramp", pgood, 1'b1);
        chk(req, "ss_start cleared", ss_start, 1'b0);
        ss_done = 1'b0;
    endtask

    task automatic t_reset();
        step(); step();
        chk("R1", "pgood in reset", pgood, 1'b0);
        chk("R1", "latched in reset", latched_off, 1'b0);
        chk("R1", "ss_start in reset", ss_start, 1'b0);
        rst_n = 1'b1;
        step(); step();
        chk("R1", "pgood after reset", pgood, 1'b0);
        chk("R1", "ss_start idle", ss_start, 1'b0);
    endtask

    task automatic t_startup();
        en = 2'b01; por_ok = 1'b1;
        step();
        chk("R2", "no start with one enable low", ss_start, 1'b0);
        en = 2'b11;
        step();
        chk("R2", "ss_start pulse", ss_start, 1'b1);
        step();
        chk("R2", "ss_start one cycle", ss_start, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R2", "pgood low in ramp", pgood, 1'b0);
        end
        ss_done = 1'b1;
        step();
        chk("R3", "pgood after ramp done", pgood, 1'b1);
        ss_done = 1'b0;
        go_off();
    endtask

    task automatic t_ramp_with_uv();
        quiet_flags();
        en = '1; por_ok = 1'b1;
        step();
        chk("R4", "ss_start", ss_start, 1'b1);
        uv_flag = 1'b1; ss_done = 1'b1;
        step();
        chk("R4", "pgood held while uv", pgood, 1'b0);
        ss_done = 1'b0;
        step();
        chk("R4", "pgood still low", pgood, 1'b0);
        uv_flag = 1'b0;
        step();
        chk("R4", "pgood after uv clears", pgood, 1'b1);
        chk("R4", "no restart", ss_start, 1'b0);
        go_off();
    endtask

    task automatic t_uv_regulate();
        bring_up("R5");
        uv_flag = 1'b1;
        step();
        chk("R5", "pgood on uv", pgood, 1'b0);
        chk("R5", "not latched on uv", latched_off, 1'b0);
        step();
        chk("R5", "pgood held low", pgood, 1'b0);
        uv_flag = 1'b0;
        step();
        chk("R5", "pgood recovers", pgood, 1'b1);
        chk("R5", "no ss_start on recovery", ss_start, 1'b0);
        go_off();
    endtask

    task automatic t_ov_latch_en_clear();
        bring_up("R6");
        ov_flag = 1'b1;
        step();
        chk("R6", "pgood on ov", pgood, 1'b0);
        chk("R6", "latched on ov", latched_off, 1'b1);
        ov_flag = 1'b0;
        for (int i = 0; i < 3; i++) begin
            ss_done = ~ss_done;
            noload_code = (i == 1);
            step();
            chk("R8", "latch holds", latched_off, 1'b1);
            chk("R8", "pgood stays low", pgood, 1'b0);
            chk("R8", "no restart while latched", ss_start, 1'b0);
        end
        ss_done = 1'b0; noload_code = 1'b0;
        en = 2'b10;
        step();
        chk("R9", "latch cleared by enable", latched_off, 1'b0);
        en = 2'b11;
        step();
        chk("R9", "new ss_start", ss_start, 1'b1);
        step();
        chk("R9", "pgood low before ramp done", pgood, 1'b0);
        ss_done = 1'b1;
        step();
        chk("R9", "pgood after new ramp", pgood, 1'b1);
        go_off();
    endtask

    task automatic t_oc_in_ramp_por_clear();
        quiet_flags();
        en = '1; por_ok = 1'b1;
        step();
        oc_flag = 1'b1;
        step();
        chk("R6", "latched on oc in ramp", latched_off, 1'b1);
        oc_flag = 1'b0;
        por_ok = 1'b0;
        step();
        chk("R9", "latch cleared by por", latched_off, 1'b0);
        por_ok = 1'b1;
        step();
        chk("R9", "ss_start after por", ss_start, 1'b1);
        go_off();
    endtask

    task automatic t_uv_ov_together();
        bring_up("R7");
        uv_flag = 1'b1; ov_flag = 1'b1;
        step();
        chk("R7", "latching wins", latched_off, 1'b1);
        chk("R7", "pgood low", pgood, 1'b0);
        quiet_flags();
        go_off();
        chk("R9", "cleared after disable", latched_off, 1'b0);
    endtask

    task automatic t_disable();
        bring_up("R10");
        noload_code = 1'b1;
        step();
        chk("R10", "pgood on noload", pgood, 1'b0);
        chk("R10", "no latch on noload", latched_off, 1'b0);
        noload_code = 1'b0;
        step();
        chk("R10", "restart after noload", ss_start, 1'b1);
        en = 2'b01;
        step();
        chk("R10", "pgood low after enable drop", pgood, 1'b0);
        en = 2'b11;
        step();
        chk("R10", "restart after enable", ss_start, 1'b1);
        ss_done = 1'b1;
        step();
        chk("R10", "regulating again", pgood, 1'b1);
        ss_done = 1'b0;
        go_off();
    endtask

    initial begin
        t_reset();
        t_startup();
        t_ramp_with_uv();
        t_uv_regulate();
        t_ov_latch_en_clear();
        t_oc_in_ramp_por_clear();
        t_uv_ov_together();
        t_disable();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule